// File: doc/BRIEF.md
# Adaptive encoder pulse multiplier

This block turns the two quadrature channels of an incremental rotary encoder into a count-pulse stream. The number of pulses per detent grows with how fast the shaft is turned. When the knob turns slowly, each increment gives one pulse of fixed width. When the gap between increments becomes shorter than a threshold, a short-pulse oscillator is released, and each increment then yields several pulses. When the knob turns very fast, the oscillator runs without pause. A downstream counter can therefore cover a wide range in a few turns and still allow single-step adjustment.

Both channels are assumed to be free of bounce. Inside the block they pass through a two-flop synchroniser, and edges are found on the synchronised samples. A retriggerable one-shot, started by each falling edge of channel B, measures the rotation rate. A rate flag is armed when B rises again while that one-shot is still running. The armed flag releases the oscillator. Channel A is sampled on each rising edge of B to give the direction of rotation. A two-bit selector can then pass pulses for both directions, for clockwise only, or for counterclockwise only. All timing values are parameters in microseconds (or hertz), converted to system clock cycles through a clock-frequency parameter.

Top module: `enc_pulse_mult`

## Requirements
- R1: On each synchronised rising edge of B, `dir_cw` takes the synchronised level of A: 1 means clockwise, 0 means counterclockwise. It holds between such edges.
- R2: Each synchronised falling edge of B (re)loads the one-shot for SHOT cycles, even when the one-shot is still running. The one-shot does not end between reloads.
- R3: If the low time of B is longer than SHOT cycles, each increment gives exactly one output pulse, and that pulse is exactly SHOT cycles wide.
- R4: The rate flag is set only by a rising edge of B that arrives while the one-shot is running. The flag clears in the cycle after the one-shot expires. A B low time shorter than SHOT therefore adds pulses to an increment, and a longer one does not.
- R5: While the rate flag is clear, the oscillator is held at the start of its period with its output low. When the flag sets, the oscillator output goes high in the same cycle.
- R6: While the one-shot is kept running and the rate flag is set, the output is a pulse train with period OSC_PER cycles and high time OSC_HIGH cycles.
- R7: The output is low in every cycle after one in which the one-shot was idle. The output therefore returns low within SHOT+3 cycles after the last B falling edge and stays low.
- R8: The selector `dir_sel` has these encodings: 0 and 3 pass pulses for both directions, 1 passes pulses only while `dir_cw` is 1, and 2 passes pulses only while `dir_cw` is 0. A blocked pulse leaves the output low.
- R9: A synchronous reset clears the synchroniser, the one-shot, the rate flag, the oscillator and `dir_cw`. The output is low after the first clock edge with reset high.
- R10: `pulse_out` rises on the third clock edge after the first edge that samples B low, with the one-shot idle beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder channel A, clean but asynchronous |
| enc_b | input | 1 | Encoder channel B, clean but asynchronous |
| dir_sel | input | 2 | Direction filter: 0/3 both, 1 clockwise only, 2 counterclockwise only |
| pulse_out | output | 1 | Registered count-pulse output |
| dir_cw | output | 1 | Last captured direction, 1 = clockwise |

## Verification
The fault cases differ in how soon they show at the ports:
- A one-shot that loads the wrong count shows on the first slow increment, as a pulse width different from SHOT.
- A rate flag that arms or clears at the wrong moment adds edges to, or removes edges from, an increment whose B low time lies just on either side of SHOT.
- A wrong oscillator counter changes the number of edges counted over a fixed window of fast rotation.
- A direction flag or selector fault blocks or passes a whole group of pulses. This is visible within one increment after the direction changes.

// File: rtl/encm_pkg.sv
package encm_pkg;

    typedef enum logic [1:0] {
        SEL_ANY  = 2'd0,
        SEL_CW   = 2'd1,
        SEL_CCW  = 2'd2,
        SEL_ANY2 = 2'd3
    } dir_sel_e;

    // Decide whether a pulse may leave the block for the captured direction.
    function automatic logic dir_pass(input dir_sel_e sel, input logic cw);
        logic ok;
        case (sel)
            SEL_CW:  ok = cw;
            SEL_CCW: ok = ~cw;
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/encm_sync.sv
module encm_sync #(
    parameter int CH     = 2,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] raw,
    output logic [CH-1:0] lvl
);
    typedef struct packed {
        logic [STAGES-1:0][CH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.pipe[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lvl = st_q.pipe[STAGES-1];
endmodule

// File: rtl/encm_edge.sv
module encm_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = lvl & ~st_q.prev;
    assign fall = ~lvl & st_q.prev;
endmodule

// File: rtl/encm_oneshot.sv
module encm_oneshot #(
    parameter int WIDTH_CYC = 2500000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(WIDTH_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(WIDTH_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } shot_st_t;

    shot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.cnt = LOAD;                 // retrigger restarts full width
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
endmodule

// File: rtl/encm_burst_osc.sv
module encm_burst_osc #(
    parameter int PER_CYC  = 166666,
    parameter int HIGH_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic shot_active,
    input  logic b_rise,
    output logic rate,
    output logic level
);
    localparam int CW = (PER_CYC > 1) ? $clog2(PER_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PER_CYC - 1);
    localparam logic [CW:0]   HIGH = (CW+1)'(HIGH_CYC);

    typedef struct packed {
        logic          rate;
        logic [CW-1:0] cnt;
    } osc_st_t;

    osc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // rate flag: armed by B rising while the one-shot still runs
        if (!shot_active)  st_d.rate = 1'b0;
        else if (b_rise)   st_d.rate = 1'b1;
        // oscillator counter: held at zero while the flag is clear
        if (!st_q.rate)            st_d.cnt = '0;
        else if (st_q.cnt == LAST) st_d.cnt = '0;
        else                       st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rate  = st_q.rate;
    assign level = st_q.rate && ({1'b0, st_q.cnt} < HIGH);
endmodule

// File: rtl/enc_pulse_mult.sv
module enc_pulse_mult #(
    parameter int CLK_HZ      = 100000000,
    parameter int SHOT_US     = 25000,
    parameter int OSC_HZ      = 600,
    parameter int OSC_HIGH_US = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic [1:0] dir_sel,
    output logic       pulse_out,
    output logic       dir_cw
);
    import encm_pkg::*;

    localparam int CYC_PER_US = CLK_HZ / 1000000;
    localparam int SHOT_CYC   = CYC_PER_US * SHOT_US;
    localparam int OSC_PER    = CLK_HZ / OSC_HZ;
    localparam int OSC_HIGH   = CYC_PER_US * OSC_HIGH_US;
    localparam int CH_A       = 0;
    localparam int CH_B       = 1;

    logic [1:0] lvl;
    logic       a_lvl, b_lvl;
    logic       b_rise, b_fall;
    logic       shot_active;
    logic       rate_flag;
    logic       osc_level;

    encm_sync #(.CH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw ({enc_b, enc_a}),
        .lvl (lvl)
    );

    assign a_lvl = lvl[CH_A];
    assign b_lvl = lvl[CH_B];

    encm_edge u_bedge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (b_lvl),
        .rise (b_rise),
        .fall (b_fall)
    );

    encm_oneshot #(.WIDTH_CYC(SHOT_CYC)) u_shot (
        .clk    (clk),
        .rst    (rst),
        .trig   (b_fall),
        .active (shot_active)
    );

    encm_burst_osc #(.PER_CYC(OSC_PER), .HIGH_CYC(OSC_HIGH)) u_osc (
        .clk         (clk),
        .rst         (rst),
        .shot_active (shot_active),
        .b_rise      (b_rise),
        .rate        (rate_flag),
        .level       (osc_level)
    );

    typedef struct packed {
        logic dir;
        logic out;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    raw_pulse;

    always_comb begin
        st_d = st_q;
        if (b_rise) st_d.dir = a_lvl;
        // one-shot window, chopped by the oscillator once the rate flag is set
        raw_pulse = shot_active & (rate_flag ? osc_level : 1'b1);
        st_d.out  = raw_pulse & dir_pass(dir_sel_e'(dir_sel), st_q.dir);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse_out = st_q.out;
    assign dir_cw    = st_q.dir;
endmodule

// File: rtl/encm_checker.sv
module encm_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] dir_sel,
    input logic       a_lvl,
    input logic       b_rise,
    input logic       b_fall,
    input logic       shot_active,
    input logic       rate_q,
    input logic       osc_level,
    input logic       pulse_out,
    input logic       dir_cw
);
    AST_DIR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        b_rise |=> (dir_cw == $past(a_lvl)));                          // R1
    AST_SHOT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        b_fall |=> shot_active);                                       // R2
    AST_RATE_NEEDS_SHOT: assert property (@(posedge clk) disable iff (rst)
        rate_q |-> $past(shot_active));                                // R4
    AST_OSC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !rate_q |-> !osc_level);                                       // R5
    AST_OSC_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(rate_q) |-> osc_level);                                  // R5
    AST_QUIET_NO_SHOT: assert property (@(posedge clk) disable iff (rst)
        !shot_active |=> !pulse_out);                                  // R7
    AST_GATE_CW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (dir_sel == 2'd1 && !dir_cw) |=> !pulse_out);                  // R8
    AST_GATE_CCW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (dir_sel == 2'd2 && dir_cw) |=> !pulse_out);                   // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!pulse_out && !dir_cw && !rate_q));                   // R9
endmodule

bind enc_pulse_mult encm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .dir_sel     (dir_sel),
    .a_lvl       (a_lvl),
    .b_rise      (b_rise),
    .b_fall      (b_fall),
    .shot_active (shot_active),
    .rate_q      (rate_flag),
    .osc_level   (osc_level),
    .pulse_out   (pulse_out),
    .dir_cw      (dir_cw)
);

// File: tb/tb_enc_pulse_mult.sv
module tb_enc_pulse_mult;
    localparam int SHOT = 40;   // cycles at CLK_HZ = 1 MHz
    localparam int PER  = 10;
    localparam int HIGH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic [1:0] dir_sel = 2'd0;
    logic       pulse_out;
    logic       dir_cw;

    int checks = 0;
    int errs   = 0;
    int edges  = 0;
    int highs  = 0;
    bit prev_out = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    enc_pulse_mult #(
        .CLK_HZ(1000000), .SHOT_US(SHOT), .OSC_HZ(100000), .OSC_HIGH_US(HIGH)
    ) dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .dir_sel(dir_sel), .pulse_out(pulse_out), .dir_cw(dir_cw)
    );

    // output monitor, sampled 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        if (pulse_out && !prev_out) edges++;
        if (pulse_out) highs++;
        prev_out = pulse_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic detent(input bit cw, input int th, input int tl);
        if (cw) begin
            enc_a = 1'b1; wait_n(tl/2);
            enc_b = 1'b1; wait_n(th/2);
            enc_a = 1'b0; wait_n(th - th/2);
            enc_b = 1'b0; wait_n(tl - tl/2);
        end else begin
            enc_b = 1'b1; wait_n(th/2);
            enc_a = 1'b1; wait_n(th - th/2);
            enc_b = 1'b0; wait_n(tl/2);
            enc_a = 1'b0; wait_n(tl - tl/2);
        end
    endtask

    task automatic zero_counts();
        edges = 0;
        highs = 0;
    endtask

    // {cw, dir_sel, increments, expected pulses}; slow rotation, 60/60 cycles
    localparam logic [10:0] VECS [0:7] = '{
        {1'b1, 2'd0, 4'd3, 4'd3},
        {1'b0, 2'd0, 4'd2, 4'd2},
        {1'b1, 2'd1, 4'd2, 4'd2},
        {1'b0, 2'd1, 4'd3, 4'd0},
        {1'b0, 2'd2, 4'd2, 4'd2},
        {1'b1, 2'd2, 4'd3, 4'd0},
        {1'b1, 2'd3, 4'd1, 4'd1},
        {1'b0, 2'd3, 4'd2, 4'd2}
    };

    initial begin
        wait_n(5);
        chk(pulse_out == 1'b0, "R9 reset output", pulse_out, 0);
        chk(dir_cw == 1'b0, "R9 reset direction", dir_cw, 0);
        rst = 1'b0;
        wait_n(5);

        // table walk: R1 direction, R3 single pulse width, R8 filter
        for (int i = 0; i < 8; i++) begin
            bit       cw;
            int       n, exp;
            cw      = VECS[i][10];
            dir_sel = VECS[i][9:8];
            n       = int'(VECS[i][7:4]);
            exp     = int'(VECS[i][3:0]);
            zero_counts();
            for (int k = 0; k < n; k++) detent(cw, 60, 60);
            wait_n(100);
            chk(edges == exp, "R3/R8 pulse count", edges, exp);
            chk(highs == exp*SHOT, "R3/R8 high cycles", highs, exp*SHOT);
            chk(dir_cw == cw, "R1 direction flag", dir_cw, cw);
        end

        // R10 latency from B falling to output
        dir_sel = 2'd0;
        enc_b = 1'b1; wait_n(60);
        enc_a = 1'b1; wait_n(60);
        enc_b = 1'b0;
        wait_n(3);
        chk(pulse_out == 1'b0, "R10 still low at edge 2", pulse_out, 0);
        wait_n(1);
        chk(pulse_out == 1'b1, "R10 high at edge 3", pulse_out, 1);
        enc_a = 1'b0;
        wait_n(100);

        // R4 just above threshold: low time 45 > SHOT, single pulses
        zero_counts();
        for (int k = 0; k < 2; k++) detent(1'b1, 80, 45);
        wait_n(100);
        chk(edges == 2, "R4 no extra pulses above threshold", edges, 2);
        chk(highs == 2*SHOT, "R4 widths above threshold", highs, 2*SHOT);

        // R4/R5 below threshold: low time 20 < SHOT adds pulses
        zero_counts();
        for (int k = 0; k < 2; k++) detent(1'b1, 80, 20);
        wait_n(100);
        chk(edges > 2, "R4 extra pulses below threshold", edges, 3);

        // R6/R2 free-running oscillator during fast rotation
        fork
            begin
                for (int k = 0; k < 20; k++) detent(1'b1, 12, 12);
            end
            begin
                wait_n(150);
                zero_counts();
                wait_n(200);
                chk(edges == 200/PER, "R6 pulses in window", edges, 200/PER);
                chk(highs == (200/PER)*HIGH, "R6 high cycles in window", highs, (200/PER)*HIGH);
            end
        join
        wait_n(100);
        chk(pulse_out == 1'b0, "R7 low after stop", pulse_out, 0);
        zero_counts();
        wait_n(50);
        chk(edges == 0, "R7 no pulses when idle", edges, 0);

        // R9 reset during fast rotation
        for (int k = 0; k < 3; k++) detent(1'b1, 12, 12);
        rst = 1'b1;
        wait_n(1);
        chk(pulse_out == 1'b0, "R9 output cleared by reset", pulse_out, 0);
        chk(dir_cw == 1'b0, "R9 direction cleared by reset", dir_cw, 0);
        wait_n(3);
        rst = 1'b0;
        zero_counts();
        wait_n(60);
        chk(edges == 0, "R9 quiet after reset", edges, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end
endmodule